// File: doc/BRIEF.md
# Two-Instruction Fetch Cache Controller

This block is the front end of an instruction cache. Each lookup takes a double-word fetch address and compares its tag against a direct-mapped tag store that keeps one valid bit per line. On a hit, the block presents a pair of 32-bit instructions in the next cycle. One lookup covers two instructions, so while the pipeline runs the block launches a lookup only on every second run cycle. A branch or jump redirect forces a lookup in the cycle it arrives.

On a miss the block drops `fetch_ready` and issues a one-cycle block read request for the whole 32-byte line. It then takes four double-word beats from the system side and writes each one into the data array. The line becomes valid only after the last beat. The block then replays the lookup. If a redirect arrived while the line was being filled, the replay uses the redirect address instead of the missed address. A maintenance input clears the valid bit of a chosen line.

The controller has four states. `ST_IDLE` is ready and accepts lookups. `ST_MISS_REQ` raises the block read request. `ST_FILL` takes the refill beats. `ST_REPLAY` re-runs the pending lookup. The transitions are:
- miss: `ST_IDLE` to `ST_MISS_REQ`
- issue: `ST_MISS_REQ` to `ST_FILL`
- last beat: `ST_FILL` to `ST_REPLAY`
- replay hit: `ST_REPLAY` to `ST_IDLE`
- replay miss: `ST_REPLAY` to `ST_MISS_REQ`

Top module: `ifetch_pair_cache`

## Requirements
- R1: After reset, `fetch_ready` is 1 and `out_valid` and `mem_req` are 0. Every line is invalid, so the first lookup to any address misses.
- R2: A lookup hits when the indexed line is valid and its stored tag matches. The double-word address splits as follows: bits [1:0] select the double-word in the line, bits [5:2] are the index, and bits [28:6] are the tag. After a hit, `out_valid` is 1 for exactly one cycle, in the cycle after the lookup. In that cycle `out_instr0` holds the word at byte address {addr,3'b000} and `out_instr1` holds the word at that address plus 4.
- R3: In the ready state, a cycle with `run`=1 and `redirect`=0 launches a lookup of `fetch_dw_addr` only if the previous run cycle launched none. The first run cycle after reset launches. Cycles with `run`=0 do not advance this alternation. A cycle with `run`=1 and `redirect`=1 always launches a lookup, of `redirect_dw_addr`. Every launched lookup, including a replay, makes the next run cycle without a redirect a skipped cycle.
- R4: After a lookup misses, `fetch_ready` is 0 from the next cycle on. In that same next cycle `mem_req` is 1 for exactly one cycle, and `mem_addr` holds the line's byte address with its low five bits zero.
- R5: The refill takes four beats on `mem_rvalid`. Beat k carries double-word k of the line, with the even word on bits [31:0]. Beats may be spaced by idle cycles. After the fourth beat the line is valid with the new tag. The pending lookup is then replayed and hits, and the pair appears on the outputs.
- R6: A redirect that arrives while `fetch_ready` is 0 is held, and the latest one wins. The replay then looks up that redirect address instead of the missed one, and the pair from the missed fetch is never delivered.
- R7: While `fetch_ready` is 0, `run` and `fetch_dw_addr` are ignored, and no lookup is launched from them.
- R8: `inv_req` with `fetch_ready`=1 clears the valid bit of line `inv_index`, so the next lookup to that line misses. `inv_req` while `fetch_ready` is 0 is ignored.
- R9: A `mem_rvalid` beat outside the refill-beat state, including the request cycle, is ignored.
- R10: Two addresses with the same index and different tags evict each other, and each lookup after an eviction misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Pipeline run cycle |
| fetch_dw_addr | input | 29 | Sequential fetch double-word address |
| redirect | input | 1 | Branch or jump redirect in execute |
| redirect_dw_addr | input | 29 | Redirect double-word address |
| inv_req | input | 1 | Invalidate line by index |
| inv_index | input | 4 | Line index to invalidate |
| fetch_ready | output | 1 | Controller can accept lookups |
| out_valid | output | 1 | Instruction pair valid |
| out_instr0 | output | 32 | Instruction at the even word |
| out_instr1 | output | 32 | Instruction at the odd word |
| mem_req | output | 1 | Block read request, one cycle |
| mem_addr | output | 32 | Line-aligned byte address of the block read |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 64 | Refill beat data |

## Verification
The lookup path is driven with several patterns, and each one separates different faults:
- A cold start shows that reset leaves every line invalid.
- Repeated lookups to a filled line show that the pair lands in the right word order and the right double-word.
- Conflicting tags on one index show that the tag is actually compared rather than only the valid bit.
- Back-to-back run cycles with and without `run` gaps and redirects show whether the alternation counts run cycles, not clock cycles, and whether a redirect overrides a skip slot.

Refills are driven with idle gaps between beats, with a stray beat in the request cycle, and with redirects and invalidates injected mid-fill. These show that beats are counted correctly, that replays follow the latest redirect, and that requests arriving while not ready are dropped. A seeded random mix of addresses over three tags then runs against a reference model kept in the bench.

// File: rtl/ifpc_pkg.sv
package ifpc_pkg;
    localparam int INSTR_W = 32;
    localparam int PAIR_W  = 2 * INSTR_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MISS_REQ,
        ST_FILL,
        ST_REPLAY
    } ifpc_state_e;
endpackage

// File: rtl/ifpc_tagstore.sv
module ifpc_tagstore #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    logic [NUM_LINES-1:0] vld_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (inv_en) vld_q[inv_idx] <= 1'b0;
            if (wr_en)  vld_q[wr_idx]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    // R5: the line becomes valid once its last beat is written
    a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);

    // R8: invalidate clears the addressed line
    a_r8_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(wr_en && wr_idx == inv_idx)) |=> !vld_q[$past(inv_idx)]);
endmodule

// File: rtl/ifpc_dataram.sv
module ifpc_dataram #(
    parameter int NUM_LINES = 16,
    parameter int BEATS     = 4,
    parameter int IDX_W     = 4,
    parameter int BEAT_W    = 2,
    parameter int DATA_W    = 64
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = NUM_LINES * BEATS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_idx, wr_beat}] <= wr_data;
    end

    assign rd_data = mem_q[{rd_idx, rd_beat}];
endmodule

// File: rtl/ifpc_ctrl.sv
module ifpc_ctrl
    import ifpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DW_W   = 29,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 23,
    parameter int BEAT_W = 2,
    parameter int BEATS  = 4,
    parameter int OFF_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DW_W-1:0]   fetch_dw_addr,
    input  logic              redirect,
    input  logic [DW_W-1:0]   redirect_dw_addr,
    input  logic              inv_req,
    output logic              fetch_ready,
    output logic              out_valid,
    output logic [INSTR_W-1:0] out_instr0,
    output logic [INSTR_W-1:0] out_instr1,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [PAIR_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [BEAT_W-1:0] lk_beat,
    input  logic              lk_hit,
    input  logic [PAIR_W-1:0] rd_data,
    output logic              fill_we,
    output logic              fill_done,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [BEAT_W-1:0] fill_beat,
    output logic [PAIR_W-1:0] fill_data,
    output logic              inv_en
);
    localparam int LINE_W = DW_W - BEAT_W;

    ifpc_state_e       state_q, state_d;
    logic              phase_q;
    logic [BEAT_W-1:0] beat_q;
    logic [LINE_W-1:0] miss_line_q;
    logic [DW_W-1:0]   held_q;
    logic              out_valid_q;
    logic [PAIR_W-1:0] pair_q;
    logic              launch_idle, launch;
    logic [DW_W-1:0]   lk_dw;

    assign launch_idle = (state_q == ST_IDLE) && run && (redirect || !phase_q);
    assign launch      = launch_idle || (state_q == ST_REPLAY);
    assign lk_dw       = redirect ? redirect_dw_addr :
                         ((state_q == ST_REPLAY) ? held_q : fetch_dw_addr);
    assign lk_beat     = lk_dw[BEAT_W-1:0];
    assign lk_idx      = lk_dw[BEAT_W +: IDX_W];
    assign lk_tag      = lk_dw[DW_W-1 -: TAG_W];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (launch && !lk_hit) state_d = ST_MISS_REQ;
            ST_MISS_REQ: state_d = ST_FILL;
            ST_FILL:     if (fill_done) state_d = ST_REPLAY;
            ST_REPLAY:   state_d = lk_hit ? ST_IDLE : ST_MISS_REQ;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= 1'b0;
            beat_q      <= '0;
            miss_line_q <= '0;
            held_q      <= '0;
            out_valid_q <= 1'b0;
            pair_q      <= '0;
        end else begin
            out_valid_q <= launch && lk_hit;
            if (launch && lk_hit) pair_q <= rd_data;
            if (launch && !lk_hit) begin
                miss_line_q <= lk_dw[DW_W-1:BEAT_W];
                held_q      <= lk_dw;
            end else if ((state_q == ST_MISS_REQ || state_q == ST_FILL) && redirect) begin
                held_q <= redirect_dw_addr;
            end
            if (state_q == ST_IDLE && run)  phase_q <= launch_idle;
            else if (state_q == ST_REPLAY)  phase_q <= 1'b1;
            if (state_q == ST_MISS_REQ)     beat_q <= '0;
            else if (fill_we)               beat_q <= beat_q + BEAT_W'(1);
        end
    end

    // combinational outputs
    assign fetch_ready = (state_q == ST_IDLE);
    assign mem_req     = (state_q == ST_MISS_REQ);
    assign mem_addr    = {miss_line_q, {OFF_W{1'b0}}};
    assign out_valid   = out_valid_q;
    assign out_instr0  = pair_q[INSTR_W-1:0];
    assign out_instr1  = pair_q[PAIR_W-1:INSTR_W];
    assign fill_we     = (state_q == ST_FILL) && mem_rvalid;
    assign fill_done   = fill_we && (beat_q == BEAT_W'(BEATS - 1));
    assign fill_idx    = miss_line_q[IDX_W-1:0];
    assign fill_tag    = miss_line_q[LINE_W-1 -: TAG_W];
    assign fill_beat   = beat_q;
    assign fill_data   = mem_rdata;
    assign inv_en      = inv_req && (state_q == ST_IDLE);

    // R3: two sequential launches never follow each other
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_idle && !redirect) |=> !(launch_idle && !redirect));

    // R4: block read request lasts one cycle
    a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R2: a pair is presented only after a launched lookup
    a_r2_out_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(launch));

    // R7: no pair is delivered while beats are being taken
    a_r7_quiet_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> !out_valid);
endmodule

// File: rtl/ifetch_pair_cache.sv
module ifetch_pair_cache
    import ifpc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_LINES  = 16,
    parameter int LINE_BYTES = 32,
    localparam int BEATS     = LINE_BYTES / 8,
    localparam int BEAT_W    = $clog2(BEATS),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
    localparam int DW_W      = ADDR_W - 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [DW_W-1:0]    fetch_dw_addr,
    input  logic               redirect,
    input  logic [DW_W-1:0]    redirect_dw_addr,
    input  logic               inv_req,
    input  logic [IDX_W-1:0]   inv_index,
    output logic               fetch_ready,
    output logic               out_valid,
    output logic [INSTR_W-1:0] out_instr0,
    output logic [INSTR_W-1:0] out_instr1,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [PAIR_W-1:0]  mem_rdata
);
    logic [IDX_W-1:0]  lk_idx, fill_idx;
    logic [TAG_W-1:0]  lk_tag, fill_tag;
    logic [BEAT_W-1:0] lk_beat, fill_beat;
    logic              lk_hit, fill_we, fill_done, inv_en;
    logic [PAIR_W-1:0] rd_data, fill_data;

    ifpc_ctrl #(
        .ADDR_W(ADDR_W), .DW_W(DW_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .BEAT_W(BEAT_W), .BEATS(BEATS), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .fetch_dw_addr(fetch_dw_addr),
        .redirect(redirect), .redirect_dw_addr(redirect_dw_addr), .inv_req(inv_req),
        .fetch_ready(fetch_ready), .out_valid(out_valid),
        .out_instr0(out_instr0), .out_instr1(out_instr1),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_beat(lk_beat), .lk_hit(lk_hit),
        .rd_data(rd_data), .fill_we(fill_we), .fill_done(fill_done),
        .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_beat(fill_beat),
        .fill_data(fill_data), .inv_en(inv_en)
    );

    ifpc_tagstore #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_idx(lk_idx), .rd_tag(lk_tag), .hit(lk_hit),
        .wr_en(fill_done), .wr_idx(fill_idx), .wr_tag(fill_tag),
        .inv_en(inv_en), .inv_idx(inv_index)
    );

    ifpc_dataram #(
        .NUM_LINES(NUM_LINES), .BEATS(BEATS), .IDX_W(IDX_W),
        .BEAT_W(BEAT_W), .DATA_W(PAIR_W)
    ) u_data (
        .clk(clk), .wr_en(fill_we), .wr_idx(fill_idx), .wr_beat(fill_beat),
        .wr_data(fill_data), .rd_idx(lk_idx), .rd_beat(lk_beat), .rd_data(rd_data)
    );
endmodule

// File: tb/ifetch_pair_cache_tb_top.sv
module ifetch_pair_cache_tb_top;
    localparam int DW_W = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, redirect = 1'b0, inv_req = 1'b0, mem_rvalid = 1'b0;
    logic [28:0] fetch_dw_addr = '0, redirect_dw_addr = '0;
    logic [3:0]  inv_index = '0;
    logic [63:0] mem_rdata = '0;
    logic        fetch_ready, out_valid, mem_req;
    logic [31:0] out_instr0, out_instr1, mem_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit          mvld [16];
    logic [22:0] mtag [16];
    bit          mphase = 1'b0;

    always #10 clk = ~clk;

    ifetch_pair_cache dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .fetch_dw_addr(fetch_dw_addr),
        .redirect(redirect), .redirect_dw_addr(redirect_dw_addr),
        .inv_req(inv_req), .inv_index(inv_index), .fetch_ready(fetch_ready),
        .out_valid(out_valid), .out_instr0(out_instr0), .out_instr1(out_instr1),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] word_at(input logic [31:0] ba);
        return (ba * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [63:0] pair_at(input logic [28:0] dw);
        return {word_at({dw, 3'b100}), word_at({dw, 3'b000})};
    endfunction

    function automatic bit model_hit(input logic [28:0] dw);
        return mvld[dw[5:2]] && (mtag[dw[5:2]] == dw[28:6]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // at negedge after a miss launch edge; returns at negedge after the replay edge
    task automatic serve_refill(input logic [28:0] dw, input bit do_redir,
                                input logic [28:0] rdw, input bit do_inv);
        chk(!fetch_ready, "R4 ready low", 64'(fetch_ready), 64'd0);
        chk(mem_req, "R4 req", 64'(mem_req), 64'd1);
        chk(mem_addr == {dw[28:2], 5'b0}, "R4 addr", 64'(mem_addr), 64'({dw[28:2], 5'b0}));
        mem_rvalid = 1'b1; mem_rdata = 64'hDEAD_BEEF_DEAD_BEEF;   // R9 stray beat
        run = 1'b1; fetch_dw_addr = dw ^ 29'h40;                  // R7 ignored
        @(negedge clk);
        chk(!mem_req, "R4 req one cycle", 64'(mem_req), 64'd0);
        for (int k = 0; k < 4; k++) begin
            int gap = $urandom % 3;
            for (int g = 0; g < gap; g++) begin
                mem_rvalid = 1'b0;
                run = $urandom % 2;
                @(negedge clk);
            end
            mem_rvalid = 1'b1;
            mem_rdata  = pair_at({dw[28:2], 2'(k)});
            redirect   = do_redir && (k == 1);
            redirect_dw_addr = rdw;
            inv_req    = do_inv && (k == 2);                      // R8 ignored
            inv_index  = $urandom % 16;
            @(negedge clk);
            chk(k == 3 || !out_valid, "R5 no early pair", 64'(out_valid), 64'd0);
            redirect = 1'b0; inv_req = 1'b0;
        end
        mem_rvalid = 1'b0; run = 1'b0;
        mvld[dw[5:2]] = 1'b1; mtag[dw[5:2]] = dw[28:6];
        @(negedge clk);
    endtask

    // at negedge after a launch edge
    task automatic complete(input logic [28:0] dw, input bit do_redir,
                            input logic [28:0] rdw, input bit do_inv);
        logic [28:0] cur = dw;
        bit first = 1'b1;
        for (int it = 0; it < 4; it++) begin
            if (model_hit(cur)) begin
                chk(out_valid, "R2 hit valid", 64'(out_valid), 64'd1);
                chk({out_instr1, out_instr0} == pair_at(cur), "R2 pair",
                    {out_instr1, out_instr0}, pair_at(cur));
                chk(fetch_ready, "R5 ready after", 64'(fetch_ready), 64'd1);
                break;
            end
            chk(!out_valid, "R10 miss no pair", 64'(out_valid), 64'd0);
            serve_refill(cur, do_redir && first, rdw, do_inv);
            if (do_redir && first) cur = rdw;   // R6 replay follows redirect
            first = 1'b0;
        end
        mphase = 1'b1;
    endtask

    task automatic step(input bit r, input bit rd, input logic [28:0] fdw,
                        input logic [28:0] rdw, input bit do_redir,
                        input logic [28:0] hdw, input bit do_inv);
        bit launch = r && (rd || !mphase);
        logic [28:0] lk = rd ? rdw : fdw;
        run = r; redirect = rd; fetch_dw_addr = fdw; redirect_dw_addr = rdw;
        @(negedge clk);
        run = 1'b0; redirect = 1'b0;
        if (r) mphase = launch;
        if (launch) complete(lk, do_redir, hdw, do_inv);
        else begin
            chk(!out_valid, "R3 skip no pair", 64'(out_valid), 64'd0);
            chk(fetch_ready, "R3 skip no lookup", 64'(fetch_ready), 64'd1);
        end
    endtask

    function automatic logic [28:0] rnd_dw();
        return {23'($urandom % 3), 4'($urandom % 16), 2'($urandom % 4)};
    endfunction

    initial begin
        logic [28:0] a, b, c;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin mvld[i] = 1'b0; mtag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fetch_ready, "R1 ready", 64'(fetch_ready), 64'd1);
        chk(!out_valid, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(!mem_req, "R1 mem_req", 64'(mem_req), 64'd0);

        a = {23'd5, 4'd3, 2'd2};
        b = {23'd9, 4'd3, 2'd1};
        c = {23'd2, 4'd7, 2'd3};
        // R1 cold miss then R5 refill, R2 hit
        step(1, 0, a, '0, 0, '0, 0);
        // R3 alternation over run cycles, gaps, and redirects
        step(1, 0, a, '0, 0, '0, 0);
        step(1, 0, a + 29'd1, '0, 0, '0, 0);
        step(0, 0, a, '0, 0, '0, 0);
        step(1, 0, a, '0, 0, '0, 0);
        step(1, 1, a, a - 29'd2, 0, '0, 0);
        step(1, 1, a, a + 29'd1, 0, '0, 0);
        step(1, 0, a, '0, 0, '0, 0);
        step(1, 0, a, '0, 0, '0, 0);
        // R10 conflict eviction on index 3
        step(1, 1, a, b, 0, '0, 0);
        step(1, 1, a, a, 0, '0, 0);
        // R6 redirect during refill, replay on c
        step(1, 1, a, b, 1, c, 0);
        chk(model_hit(c), "R6 held line filled", 64'(model_hit(c)), 64'd1);
        // R8 invalidate while ready, then lookup misses
        inv_req = 1'b1; inv_index = c[5:2];
        @(negedge clk);
        inv_req = 1'b0; mvld[c[5:2]] = 1'b0;
        chk(fetch_ready, "R8 inval idle", 64'(fetch_ready), 64'd1);
        step(1, 1, a, c, 0, '0, 0);
        // R8 invalidate during fill ignored (random index)
        step(1, 1, a, a + 29'd64, 0, '0, 1);
        step(1, 1, a, c, 0, '0, 0);

        // seeded random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 8 == 0) begin
                int ix = $urandom % 16;
                inv_req = 1'b1; inv_index = 4'(ix);
                @(negedge clk);
                inv_req = 1'b0; mvld[ix] = 1'b0;
            end
            step($urandom % 4 != 0, $urandom % 3 == 0, rnd_dw(), rnd_dw(),
                 $urandom % 4 == 0, rnd_dw(), $urandom % 4 == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule